// File: doc/BRIEF.md
# Dual-Input Alternating Watchdog

This block supervises two software "kick" inputs that must toggle in a fixed order. The first input (A) has to pulse, and then the second (B). A counter stands in for a timing capacitor. Once the block is enabled, the counter climbs from a low mark to a high mark in fixed steps. It then falls back toward the low mark. A completed A-then-B pair seen while it falls makes it climb again. If it reaches the low mark first, the block emits a one-cycle timeout request for the reset sequencer.

The kick inputs are asynchronous. Each passes through a two-flop synchroniser and a rising-edge detector. A repeated pulse on one input before the other input has answered is ignored. When both inputs are tied to one clock, a pair therefore completes only on every second edge of that clock. An inhibit input halts monitoring and parks the counter at the start of a fresh climb. The enable input models the release of system reset, so every enable starts a clean watch.

Top module: `alt_kick_watchdog`

## Requirements
- R1: `timeout` is 0 during reset, and no timeout is produced on any clock edge at which `wdt_en` is sampled low.
- R2: A kick level sampled at edge k takes effect at edge k+2. This comes from two synchroniser flops. Only a low-to-high change counts; a held high level or a falling change counts nothing.
- R3: The first edge with `wdt_en` high loads the low mark. The counter then climbs by STEP per edge to the high mark and falls by STEP per edge. Without a pair, `timeout` is high after edge 1+2*(HIGH_MARK-LOW_MARK)/STEP, counted from that first enabled edge.
- R4: During the fall, an A edge followed by a later B edge turns the counter back to climbing from its current level. If the completing B edge falls on the same edge where the count would reach the low mark, the pair wins and no timeout occurs.
- R5: A second A edge before B is ignored, and one A is enough to arm the pair. A B edge with no armed A is ignored.
- R6: When A and B rise on the same edge, the A edge arms the pair if it is not yet armed; if it is already armed, the B edge completes the pair. Tied inputs thus complete on every second common edge.
- R7: Kick edges that arrive while the counter is climbing are ignored and do not arm a pair.
- R8: While `inhibit` is high, no timeout occurs and the counter is held at the low mark. From the first edge with `inhibit` low, the climb restarts. A timeout follows 2*(HIGH_MARK-LOW_MARK)/STEP edges later, with that first edge counted as the first.
- R9: `timeout` lasts exactly one cycle. It then stays low until `wdt_en` is sampled low and high again, which restarts the watch as in R3.
- R10: With A and B tied to a periodic clock, the block stays quiet when two clock periods fit inside the fall window; a clock slower than that produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_en | input | 1 | Monitoring enable; high once system reset is released |
| inhibit | input | 1 | Halts monitoring while high |
| kick_a | input | 1 | First kick input, asynchronous |
| kick_b | input | 1 | Second kick input, asynchronous |
| timeout | output | 1 | One-cycle timeout request to the reset sequencer |

## Verification
The bench drives a watch with no kicks at all, which fixes the exact timeout edge and so the climb and fall lengths. It then drives ordered A/B pulses placed at chosen edges. A-then-B pairs, A-A-B, B-B, B-then-A and same-edge pulses separate true alternation from counting any edge. Pulses placed one edge apart around the expiry point pin the synchroniser latency and the priority of a late pair over the timeout. Tied periodic clocks of a short and a long period, inhibit windows and a long random run show the every-second-edge rule and the restart behaviour. A cycle model in the bench tracks all of these.

// File: rtl/alt_kick_watchdog.sv
module alt_kick_watchdog #(
  parameter int CNT_W       = 12,
  parameter int HIGH_MARK   = 2000,
  parameter int LOW_MARK    = 64,
  parameter int STEP        = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_en,
  input  logic inhibit,
  input  logic kick_a,
  input  logic kick_b,
  output logic timeout
);

  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LO_C   = CNT_W'(LOW_MARK);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] TURN_C = CNT_W'(HIGH_MARK - STEP);
  localparam logic [CNT_W-1:0] END_C  = CNT_W'(LOW_MARK + STEP);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_DOWN, S_DONE} wd_state_e;

  wd_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic                  armed;
  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic                  last_a, last_b;
  logic                  edge_a, edge_b, pair_done, ramp_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      last_a <= 1'b0;
      last_b <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], kick_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], kick_b};
      last_a <= sync_a[SYNC_STAGES-1];
      last_b <= sync_b[SYNC_STAGES-1];
    end
  end

  assign edge_a    = sync_a[SYNC_STAGES-1] & ~last_a;
  assign edge_b    = sync_b[SYNC_STAGES-1] & ~last_b;
  assign pair_done = edge_b & armed;
  assign ramp_down = (state == S_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= LO_C;
      armed   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!wdt_en) begin
        state <= S_IDLE;
        cnt   <= LO_C;
        armed <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            state <= S_UP;
            cnt   <= LO_C;
            armed <= 1'b0;
          end
          S_UP: begin
            if (inhibit) begin
              cnt   <= LO_C;
              armed <= 1'b0;
            end else if (cnt >= TURN_C) begin
              cnt   <= HI_C;
              state <= S_DOWN;
            end else begin
              cnt <= cnt + STEP_C;
            end
          end
          S_DOWN: begin
            if (inhibit) begin
              state <= S_UP;
              cnt   <= LO_C;
              armed <= 1'b0;
            end else if (pair_done) begin
              state <= S_UP;
              armed <= 1'b0;
            end else begin
              armed <= armed | edge_a;
              if (cnt <= END_C) begin
                cnt     <= LO_C;
                state   <= S_DONE;
                timeout <= 1'b1;
              end else begin
                cnt <= cnt - STEP_C;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/alt_kick_watchdog_chk.sv
module alt_kick_watchdog_chk #(
  parameter int CNT_W     = 12,
  parameter int HIGH_MARK = 2000,
  parameter int LOW_MARK  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_en,
  input logic             inhibit,
  input logic             timeout,
  input logic             ramp_down,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LOW_MARK);

  assert_quiet_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wdt_en) |-> !timeout);

  assert_expire_from_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(ramp_down));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= LO_C) && (cnt <= HI_C));

  assert_quiet_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit) |-> !timeout);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  assert_hold_after_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && wdt_en) |=> !ramp_down);

endmodule

bind alt_kick_watchdog alt_kick_watchdog_chk #(
  .CNT_W(CNT_W), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .inhibit(inhibit),
  .timeout(timeout), .ramp_down(ramp_down), .cnt(cnt)
);

// File: tb/alt_kick_watchdog_bench.sv
`timescale 1ns/1ps
module alt_kick_watchdog_bench;

  localparam int CNT_W = 8;
  localparam int HI    = 44;
  localparam int LO    = 4;
  localparam int STP   = 4;
  localparam int NSTEP = (HI - LO) / STP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_en = 1'b0, inhibit = 1'b0, kick_a = 1'b0, kick_b = 1'b0;
  logic timeout;

  always #10 clk = ~clk;

  alt_kick_watchdog #(.CNT_W(CNT_W), .HIGH_MARK(HI), .LOW_MARK(LO), .STEP(STP), .SYNC_STAGES(2))
    u_alt_kick_watchdog (.clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .inhibit(inhibit),
                         .kick_a(kick_a), .kick_b(kick_b), .timeout(timeout));

  int n_cmp = 0, n_bad = 0;
  int edge_no = 0, to_count = 0, first_to = 0;
  int cyc = 0;
  string cur_req = "R1";

  function automatic int expiry_edge();
    return 1 + 2 * NSTEP;
  endfunction

  function automatic int resume_expiry(input int first_low_edge);
    return first_low_edge + 2 * NSTEP - 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // cycle model of the requirements
  int  m_lvl = LO;
  int  m_mode = 0;   // 0 off, 1 climbing, 2 falling, 3 spent
  bit  m_half = 0;
  bit  [2:0] ha = '0, hb = '0;
  bit  exp_to = 0;

  always @(posedge clk) begin
    bit ra, rb;
    if (!rst_n) begin
      m_lvl = LO; m_mode = 0; m_half = 0; ha = '0; hb = '0; exp_to = 0;
    end else begin
      ra = ha[1] & ~ha[2];
      rb = hb[1] & ~hb[2];
      ha = {ha[1:0], kick_a};
      hb = {hb[1:0], kick_b};
      exp_to = 0;
      if (!wdt_en) begin
        m_mode = 0; m_lvl = LO; m_half = 0;
      end else if (m_mode == 0) begin
        m_mode = 1; m_lvl = LO; m_half = 0;
      end else if (m_mode == 3) begin
      end else if (inhibit) begin
        m_mode = 1; m_lvl = LO; m_half = 0;
      end else if (m_mode == 1) begin
        m_lvl = m_lvl + STP;
        if (m_lvl >= HI) begin m_lvl = HI; m_mode = 2; end
      end else begin
        if (rb && m_half) begin
          m_mode = 1; m_half = 0;
        end else begin
          if (ra) m_half = 1;
          m_lvl = m_lvl - STP;
          if (m_lvl <= LO) begin m_lvl = LO; m_mode = 3; exp_to = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) check(cur_req, "timeout vs model", int'(timeout), int'(exp_to));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic tick(input logic a, input logic b);
    kick_a = a;
    kick_b = b;
    @(posedge clk);
    @(negedge clk);
    edge_no++;
    if (timeout) begin
      to_count++;
      if (first_to == 0) first_to = edge_no;
    end
  endtask

  task automatic begin_phase(input string req);
    cur_req = req;
    wdt_en = 1'b0; inhibit = 1'b0;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    wdt_en = 1'b1;
    edge_no = 0; to_count = 0; first_to = 0;
  endtask

  task automatic pulse_run(input int ta1, input int ta2, input int tb1, input int tb2, input int n);
    for (int t = 1; t <= n; t++)
      tick(t == ta1 || t == ta2, t == tb1 || t == tb2);
  endtask

  task automatic periodic_run(input int period, input int n);
    for (int t = 1; t <= n; t++) begin
      logic v;
      v = (t % period) < (period / 2);
      tick(v, v);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a1b));
    repeat (4) @(negedge clk);
    check("R1", "timeout in reset", int'(timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "timeout after reset", int'(timeout), 0);

    // R1: disabled, random kicks
    cur_req = "R1"; edge_no = 0; to_count = 0; first_to = 0;
    for (int t = 0; t < 40; t++) tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    check("R1", "timeouts while disabled", to_count, 0);

    // R3 / R9: no kicks
    begin_phase("R3");
    pulse_run(0, 0, 0, 0, 90);
    check("R3", "expiry edge without kicks", first_to, expiry_edge());
    check("R9", "single timeout then hold", to_count, 1);
    begin_phase("R9");
    pulse_run(0, 0, 0, 0, 30);
    check("R9", "expiry edge after re-enable", first_to, expiry_edge());

    // R4: steady ordered pairs
    begin_phase("R4");
    for (int t = 1; t <= 200; t++) tick((t % 4) == 0, (t % 4) == 2);
    check("R4", "timeouts with steady A-then-B", to_count, 0);

    // R4: late pair wins over expiry, one edge later loses
    begin_phase("R4");
    pulse_run(17, 0, 19, 0, 24);
    check("R4", "pair completing on expiry edge", to_count, 0);
    begin_phase("R2");
    pulse_run(17, 0, 20, 0, 24);
    check("R2", "pair one edge too late", first_to, expiry_edge());

    // R5: A-A-B completes, then climb and full fall
    begin_phase("R5");
    pulse_run(10, 12, 14, 0, 40);
    check("R5", "A-A-B then next expiry", first_to, 30);
    begin_phase("R5");
    pulse_run(0, 0, 10, 12, 30);
    check("R5", "B-B without A", first_to, expiry_edge());
    begin_phase("R5");
    pulse_run(14, 0, 10, 0, 30);
    check("R5", "B then A", first_to, expiry_edge());

    // R6: same-edge pulses
    begin_phase("R6");
    pulse_run(12, 0, 12, 0, 30);
    check("R6", "one common edge only arms", first_to, expiry_edge());
    begin_phase("R6");
    pulse_run(10, 12, 10, 12, 35);
    check("R6", "second common edge completes", first_to, 26);

    // R7: edge during climb ignored
    begin_phase("R7");
    pulse_run(3, 0, 12, 0, 30);
    check("R7", "A during climb not armed", first_to, expiry_edge());

    // R2: falling change on B does not count
    begin_phase("R2");
    for (int t = 1; t <= 30; t++) tick(t == 10, t <= 11);
    check("R2", "falling B ignored", first_to, expiry_edge());

    // R8: inhibit from start, and inhibit during fall
    begin_phase("R8");
    inhibit = 1'b1;
    pulse_run(0, 0, 0, 0, 80);
    check("R8", "no timeout while inhibited", to_count, 0);
    inhibit = 1'b0;
    pulse_run(0, 0, 0, 0, 30);
    check("R8", "expiry after release", first_to, resume_expiry(81));
    begin_phase("R8");
    pulse_run(0, 0, 0, 0, 14);
    inhibit = 1'b1;
    pulse_run(0, 0, 0, 0, 26);
    check("R8", "inhibit during fall", to_count, 0);
    inhibit = 1'b0;
    pulse_run(0, 0, 0, 0, 30);
    check("R8", "expiry after mid-fall release", first_to, resume_expiry(41));
    check("R8", "single timeout after release", to_count, 1);

    // R10: tied periodic clock
    begin_phase("R10");
    periodic_run(4, 200);
    check("R10", "fast tied clock keeps quiet", to_count, 0);
    begin_phase("R10");
    periodic_run(12, 200);
    check("R10", "slow tied clock expires", int'(to_count > 0), 1);

    // random mix against the model
    cur_req = "R4";
    wdt_en = 1'b1;
    for (int t = 0; t < 4000; t++) begin
      if ($urandom_range(0, 199) == 0) wdt_en = ~wdt_en;
      if ($urandom_range(0, 149) == 0) inhibit = ~inhibit;
      tick($urandom_range(0, 6) == 0, $urandom_range(0, 6) == 0);
    end
    summary();
  end

endmodule